// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device and decides when an embedded program or erase operation has finished. Once the command sequence has been written to the device, the host pulses `start`. The poller then issues status reads through a request/acknowledge read port and samples the returned byte. It compares the toggle bit across consecutive reads and watches the device's time-limit flag.

The poller makes its decision only after it has captured two reads. If the toggle bit holds its value, the operation is complete. If the bit is still changing and the time-limit flag is low, polling goes on. If the bit is still changing and the flag is high, the poller takes one more pair of reads and compares those two with each other. This catches the race in which toggling stopped in the same moment that the flag was raised. A mismatch in that final pair is a failure.

On a failure the poller raises a one-cycle request for a reset command to be written. A configurable read-count watchdog forces a failure when the bus never settles. The bit positions, the data width and the watchdog limit are parameters.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `busy`, `rd_req`, `done`, `pass` and `reset_req` are all low.
- R2: A `start` pulse while idle raises `busy` and `rd_req` on the next clock edge. `rd_req` stays high until a cycle in which `rd_ack` is high, and each such cycle delivers one status byte on `rd_data`.
- R3: No outcome is reported before at least two status reads have been acknowledged since `start`.
- R4: If the toggle bit (bit 6 of the status byte) has the same value in two consecutive reads, `done` rises with `pass` high on the edge that follows the acknowledge of the second read. `busy` is low in that same cycle.
- R5: If the toggle bit differs between two consecutive reads and bit 5 of the later read is low, one more read is taken and compared with the one before it.
- R6: If the toggle bit differs and bit 5 of the later read is high, two further reads are taken and their toggle bits are compared with each other. A match reports a pass.
- R7: If the toggle bits of that final pair differ, the outcome is a fail (`done` high, `pass` low), and `reset_req` is high in the same cycle as `done`.
- R8: `done` and `reset_req` are single-cycle pulses. `pass` is high only while `done` is high. `reset_req` is high exactly when `done` is high and `pass` is low.
- R9: With the watchdog enabled, if MAX_READS reads are acknowledged without a decision, the outcome is a fail with `reset_req`. A pass decision made on the MAX_READS-th read still counts as a pass.
- R10: A `start` pulse while `busy` is high is ignored. The number of reads and the outcome stay as they would have been without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin polling (honoured only while idle) |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; rd_data valid in this cycle |
| rd_data | input | DATA_W | Status byte returned by the read |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Outcome, valid with done: 1 success, 0 fail |
| reset_req | output | 1 | One-cycle request to write a reset command |

## Verification
The hardest path to reach from the ports is the confirming pair. It requires a toggling status with the limit flag set, followed by two reads that either agree or disagree, and the fail branch must also avoid being cut short by the watchdog. Directed byte sequences place the limit flag on exactly the read that follows a toggle, for both outcomes of the final pair. Random status streams with a sparse limit flag and random acknowledge latency cover the rest, including runs that exhaust the watchdog. A stray `start` is pulsed during a poll to show that it is ignored.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   typedef enum logic [1:0] {
      PH_FIRST = 2'd0,
      PH_POLL  = 2'd1,
      PH_CONF1 = 2'd2,
      PH_CONF2 = 2'd3
   } tpc_phase_e;
endpackage

// File: rtl/tpc_read_watchdog.sv
module tpc_read_watchdog #(
   parameter bit          ENABLE    = 1'b1,
   parameter int unsigned MAX_READS = 1024,
   localparam int unsigned CNT_W    = $clog2(MAX_READS + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic tick,
   output logic last
);
   if (ENABLE) begin : g_on
      logic [CNT_W-1:0] count_q;
      always_ff @(posedge clk) begin
         if (rst || clear) count_q <= '0;
         else if (tick)    count_q <= count_q + 1'b1;
      end
      assign last = tick && (count_q == CNT_W'(MAX_READS - 1));
   end else begin : g_off
      logic unused_wd;
      assign unused_wd = &{1'b0, clk, rst, clear, tick};
      assign last = 1'b0;
   end
endmodule

// File: rtl/tpc_decide.sv
module tpc_decide
   import tpc_pkg::*;
(
   input  tpc_phase_e phase,
   input  logic       ref_bit,
   input  logic       new_bit,
   input  logic       limit_bit,
   input  logic       wd_last,
   output tpc_phase_e next_phase,
   output logic       finish,
   output logic       ok
);
   always_comb begin
      next_phase = phase;
      finish     = 1'b0;
      ok         = 1'b0;
      unique case (phase)
         PH_FIRST: next_phase = PH_POLL;
         PH_POLL: begin
            if (new_bit == ref_bit) begin
               finish = 1'b1;
               ok     = 1'b1;
            end else if (limit_bit) begin
               next_phase = PH_CONF1;
            end
         end
         PH_CONF1: next_phase = PH_CONF2;
         PH_CONF2: begin
            finish = 1'b1;
            ok     = (new_bit == ref_bit);
         end
         default: next_phase = PH_FIRST;
      endcase
      // watchdog only overrides an undecided read
      if (!finish && wd_last) begin
         finish = 1'b1;
         ok     = 1'b0;
      end
   end
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
   import tpc_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TOGGLE_BIT = 6,
   parameter int unsigned LIMIT_BIT  = 5,
   parameter bit          WDOG_EN    = 1'b1,
   parameter int unsigned MAX_READS  = 1024
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic              rd_req,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              reset_req
);
   if (TOGGLE_BIT >= DATA_W) begin : g_bad_tog
      $error("TOGGLE_BIT outside data width");
   end
   if (LIMIT_BIT >= DATA_W || LIMIT_BIT == TOGGLE_BIT) begin : g_bad_lim
      $error("LIMIT_BIT invalid");
   end
   if (MAX_READS < 2) begin : g_bad_max
      $error("MAX_READS must be at least 2");
   end

   logic       busy_q, done_q, pass_q, rreq_q, ref_q;
   tpc_phase_e phase_q, phase_d;
   logic       finish, ok, wd_last;
   logic       accept, sample;

   assign accept = start && !busy_q;
   assign sample = busy_q && rd_ack;

   tpc_read_watchdog #(
      .ENABLE   (WDOG_EN),
      .MAX_READS(MAX_READS)
   ) u_wd (
      .clk  (clk),
      .rst  (rst),
      .clear(accept),
      .tick (sample),
      .last (wd_last)
   );

   tpc_decide u_dec (
      .phase     (phase_q),
      .ref_bit   (ref_q),
      .new_bit   (rd_data[TOGGLE_BIT]),
      .limit_bit (rd_data[LIMIT_BIT]),
      .wd_last   (wd_last),
      .next_phase(phase_d),
      .finish    (finish),
      .ok        (ok)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         phase_q <= PH_FIRST;
         ref_q   <= 1'b0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         rreq_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
         rreq_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            phase_q <= PH_FIRST;
         end else if (sample) begin
            ref_q   <= rd_data[TOGGLE_BIT];
            phase_q <= phase_d;
            if (finish) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               pass_q <= ok;
               rreq_q <= !ok;
            end
         end
      end
   end

   logic unused_rd;
   assign unused_rd = ^rd_data;

   assign rd_req    = busy_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign pass      = pass_q;
   assign reset_req = rreq_q;
endmodule

// File: rtl/toggle_poll_chk.sv
module toggle_poll_chk #(
   parameter bit          WDOG_EN   = 1'b1,
   parameter int unsigned MAX_READS = 1024
) (
   input logic clk,
   input logic rst,
   input logic start,
   input logic rd_req,
   input logic rd_ack,
   input logic busy,
   input logic done,
   input logic pass,
   input logic reset_req
);
   localparam int unsigned CW = $clog2(MAX_READS + 2);
   logic [CW-1:0] acks_q;

   always_ff @(posedge clk) begin
      if (rst || done)          acks_q <= '0;
      else if (rd_req && rd_ack) acks_q <= acks_q + 1'b1;
   end

   a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !rd_req);
   a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
      rd_req && !rd_ack |=> rd_req);
   a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
      start && !busy && !done |=> busy);
   a_r3_two_reads: assert property (@(posedge clk) disable iff (rst)
      done |-> acks_q >= CW'(2));
   a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r8_pass_with_done: assert property (@(posedge clk) disable iff (rst)
      pass |-> done);
   a_r7_rreq_on_fail: assert property (@(posedge clk) disable iff (rst)
      reset_req == (done && !pass));
   a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
      busy && !rd_ack |=> busy);
   a_r9_read_bound: assert property (@(posedge clk) disable iff (rst)
      WDOG_EN |-> acks_q <= CW'(MAX_READS));
endmodule

bind toggle_poll_ctrl toggle_poll_chk #(
   .WDOG_EN  (WDOG_EN),
   .MAX_READS(MAX_READS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .rd_req   (rd_req),
   .rd_ack   (rd_ack),
   .busy     (busy),
   .done     (done),
   .pass     (pass),
   .reset_req(reset_req)
);

// File: tb/toggle_poll_ctrl_test.sv
module toggle_poll_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAXR       = 12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       rd_ack = 1'b0;
   logic [7:0] rd_data = '0;
   logic       rd_req, busy, done, pass, reset_req;

   int vectors = 0;
   int errors  = 0;
   logic [7:0] mem [0:63];

   always #(CLK_PERIOD/2) clk = ~clk;

   toggle_poll_ctrl #(.MAX_READS(MAXR)) uut (
      .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
      .rd_data(rd_data), .busy(busy), .done(done), .pass(pass),
      .reset_req(reset_req));

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // expected reads and outcome from the requirements
   task automatic model(output int nreads, output bit ok);
      int  ph = 0;
      bit  refb = 1'b0;
      nreads = 0;
      ok = 1'b0;
      for (int i = 0; i < 64; i++) begin
         bit fin = 1'b0;
         bit b6 = mem[i][6];
         nreads = i + 1;
         case (ph)
            0: ph = 1;
            1: if (b6 == refb) begin fin = 1; ok = 1; end
               else if (mem[i][5]) ph = 2;
            2: ph = 3;
            default: begin fin = 1; ok = (b6 == refb); end
         endcase
         refb = b6;
         if (fin) return;
         if (nreads == MAXR) begin ok = 0; return; end
      end
   endtask

   task automatic run_case(input string req, input int stray_at);
      int  exp_n, got_n, cyc, wait_c;
      bit  exp_ok, seen, early, acked;
      model(exp_n, exp_ok);
      got_n = 0; seen = 0; early = 0; acked = 0; cyc = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({req, " R2 busy after start"}, busy, 1);
      chk({req, " R2 req after start"}, rd_req, 1);
      wait_c = $urandom % 3;
      while (!seen && cyc < 400) begin
         if (acked) begin got_n++; acked = 0; rd_ack = 1'b0; end
         if (done) begin
            seen = 1;
            chk({req, " R3/R5/R6/R9 read count"}, got_n, exp_n);
            chk({req, " R4/R6/R7 pass"}, pass, int'(exp_ok));
            chk({req, " R7/R8 reset_req"}, reset_req, int'(!exp_ok));
            chk({req, " R4 busy low at done"}, busy, 0);
         end else begin
            if (got_n < 2 && (done || !busy)) early = 1;
            start = (cyc == stray_at);
            if (rd_req) begin
               if (wait_c == 0) begin
                  rd_ack = 1'b1; rd_data = mem[got_n]; acked = 1;
                  wait_c = $urandom % 3;
               end else wait_c--;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
         end
      end
      chk({req, " watchdog of bench"}, int'(seen), 1);
      chk({req, " R3 no early end"}, int'(early), 0);
      @(negedge clk);
      chk({req, " R8 done single"}, done, 0);
      chk({req, " R8 reset_req single"}, reset_req, 0);
      chk({req, " R8 pass low"}, pass, 0);
   endtask

   function automatic logic [7:0] sb(input bit t, input bit lim);
      return {1'b0, t, lim, 5'h0A};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 rd_req", rd_req, 0);
      chk("R1 done", done, 0);
      chk("R1 reset_req", reset_req, 0);
      rst = 1'b0;
      void'($urandom(32'h5EED_1234));

      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      run_case("R4 immediate", -1);

      for (int i = 0; i < 64; i++) mem[i] = (i < 5) ? sb(i[0], 0) : sb(1, 0);
      run_case("R5 poll then settle", -1);

      mem[0] = sb(0,0); mem[1] = sb(1,1); mem[2] = sb(1,1); mem[3] = sb(1,1);
      run_case("R6 confirm pass", -1);

      mem[0] = sb(0,0); mem[1] = sb(1,1); mem[2] = sb(0,1); mem[3] = sb(1,1);
      run_case("R7 confirm fail", -1);

      mem[0] = sb(0,1); mem[1] = sb(1,1); mem[2] = sb(0,1); mem[3] = sb(0,1);
      run_case("R6 race on limit", -1);

      for (int i = 0; i < 64; i++) mem[i] = sb(i[0], 0);
      run_case("R9 watchdog", -1);

      for (int i = 0; i < 64; i++) mem[i] = (i < MAXR-1) ? sb(i[0], 0) : sb(!i[0], 0);
      run_case("R9 pass on last read", -1);

      for (int i = 0; i < 64; i++) mem[i] = (i < 6) ? sb(i[0], 0) : sb(0, 0);
      run_case("R10 stray start", 3);

      for (int n = 0; n < 40; n++) begin
         for (int i = 0; i < 64; i++)
            mem[i] = ($urandom % 256) & ((($urandom % 6) == 0) ? 8'hFF : 8'hDF);
         run_case("R5 random", (n % 4 == 0) ? 2 : -1);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule